// File: doc/BRIEF.md
# Mersenne-Twister Seed Expander

This block turns one 32-bit seed into the full initial state table of a 32-bit Mersenne-Twister generator. It writes the table word by word into an external state memory through a simple write port (enable, address, data). Word 0 is the seed itself. Each later word n is derived from word n-1. The previous word is folded with its own top two bits, multiplied by 1812433253, and the index n is added, all modulo 2^32.

The multiply has no general-purpose multiplier behind it. It is broken into shift-and-add terms spread over a four-stage register pipeline. The loop index is merged into the third stage, so that no stage carries more than a short adder chain. One word leaves the pipeline every four clocks, and the memory is written only in the first cycle of each group of four. A start pulse loads a new seed and restarts the table from word 0. Leaving reset runs the same sequence with a built-in default seed. A done flag reports that the last entry has been written. The block is meant to sit next to the generator's state RAM, which it fills before the generator starts drawing numbers.

Top module: `mt_seed_expander`

## Requirements
- R1: While rst is high, wr_en and done are 0. On the first clock edge with rst low (and start low), the block starts an expansion of DEFAULT_SEED (default 5489), so wr_en is 1 with wr_addr 0 and wr_data equal to DEFAULT_SEED in the following cycle.
- R2: A start pulse sampled at a clock edge makes the next cycle a write with wr_addr 0 and wr_data equal to the seed sampled with start.
- R3: During an expansion, writes occur exactly every fourth cycle and wr_en is 0 in between. Addresses run from 0 up to TABLE_N-1 in steps of one, and wr_addr is never above TABLE_N-1 while wr_en is 1.
- R4: The word written at address n (n >= 1) equals (1812433253 * (w ^ (w >> 30)) + n) mod 2^32, where w is the word written at address n-1. For seed 5489 the word at address 1 is 1301868182.
- R5: done is 0 during an expansion. It rises in the cycle after the write to address TABLE_N-1, which is 4*(TABLE_N-1)+1 cycles after the write to address 0, exactly TABLE_N writes having been made. It then stays 1, with wr_en 0, until the next start or reset.
- R6: A start pulse during an expansion abandons it. The next cycle writes address 0 with the new seed, done stays 0, and the whole table is produced from the new seed.
- R7: A start pulse while done is 1 clears done in the next cycle and runs a full new expansion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse: load seed and restart expansion |
| seed | input | 32 | Seed value, sampled when start is high |
| wr_en | output | 1 | State memory write enable |
| wr_addr | output | IDX_W (10) | State memory write address (table index) |
| wr_data | output | 32 | State word to write |
| done | output | 1 | Table complete; held until next start or reset |

## Verification
The properties assume that rst is held high for at least one clock edge and that start and seed change only between edges. The reset-release property holds only when start is low in the release cycle, since a start there overrides the default seed. The bench drives every input on the falling edge and issues start as a one-cycle pulse. It never raises start in the cycle that reset is released. Restart points are drawn from a range that includes write cycles, the middle of a word's pipeline, and the cycle just before the last write, so the restart and gap properties are exercised on both sides of a write.

// File: rtl/mt_seed_pkg.sv
`timescale 1ns/1ps
package mt_seed_pkg;

   localparam int unsigned WORD_W  = 32;
   localparam int unsigned PHASES  = 4;
   localparam int unsigned PH_WRITE = 0;
   localparam int unsigned PH_LAST  = PHASES - 1;

   localparam logic [WORD_W-1:0] MT_INIT_MULT = 32'd1812433253;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [PHASES-1:0] phase_t;

   // second pipeline stage: partial products
   typedef struct packed {
      word_t p37;    // 37 * x (or full product in the multiplier variant)
      word_t pdiff;  // (2^19 - 2^15) * x
   } stage2_t;

   // third pipeline stage: two halves of the next word
   typedef struct packed {
      word_t sum;      // 37x + 2^6*37x + (2^19-2^15)x
      word_t idxterm;  // index - 2^26*37x
   } stage3_t;

endpackage

// File: rtl/mt_seed_sequencer.sv
`timescale 1ns/1ps
module mt_seed_sequencer
   import mt_seed_pkg::*;
#(
   parameter int unsigned TABLE_N = 624,
   parameter int unsigned IDX_W   = 10
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   output logic             load,
   output logic             active,
   output phase_t           phase,
   output logic [IDX_W-1:0] idx,
   output logic             done
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TABLE_N - 1);
   localparam phase_t           PH_INIT  = phase_t'(1);

   // set by reset, consumed by the first edge after release
   logic kick;

   assign load = !rst && (start || kick);

   always_ff @(posedge clk) begin
      if (rst) begin
         kick   <= 1'b1;
         active <= 1'b0;
         phase  <= PH_INIT;
         idx    <= '0;
         done   <= 1'b0;
      end else if (load) begin
         kick   <= 1'b0;
         active <= 1'b1;
         phase  <= PH_INIT;
         idx    <= '0;
         done   <= 1'b0;
      end else if (active) begin
         phase <= {phase[PHASES-2:0], phase[PHASES-1]};
         if (phase[PH_WRITE]) begin
            if (idx == LAST_IDX) begin
               active <= 1'b0;
               done   <= 1'b1;
            end else begin
               idx <= idx + IDX_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/mt_seed_mix.sv
`timescale 1ns/1ps
module mt_seed_mix
   import mt_seed_pkg::*;
#(
   parameter int unsigned IDX_W     = 10,
   parameter bit          SHIFT_ADD = 1'b1,
   parameter word_t       MULT      = MT_INIT_MULT
)(
   input  logic             clk,
   input  word_t            word_in,
   input  logic [IDX_W-1:0] idx,
   output stage3_t          s3
);

   localparam int unsigned PAD = WORD_W - IDX_W;

   word_t   s1;
   stage2_t s2;
   word_t   idx_w;

   assign idx_w = {{PAD{1'b0}}, idx};

   // stage 1: fold the two top bits into the two low bits
   always_ff @(posedge clk) begin
      s1 <= {word_in[WORD_W-1:2], word_in[1:0] ^ word_in[WORD_W-1:WORD_W-2]};
   end

   generate
      if (SHIFT_ADD) begin : g_shift_add
         // stage 2: 37x and (2^19 - 2^15)x
         always_ff @(posedge clk) begin
            s2.p37   <= s1 + (s1 << 2) + (s1 << 5);
            s2.pdiff <= (s1 << 19) - (s1 << 15);
         end
         // stage 3: positive sum and index minus the 2^26 term
         always_ff @(posedge clk) begin
            s3.sum     <= s2.p37 + (s2.p37 << 6) + s2.pdiff;
            s3.idxterm <= idx_w - (s2.p37 << 26);
         end
      end else begin : g_mult
         // stage 2: full constant product
         always_ff @(posedge clk) begin
            s2.p37   <= s1 * MULT;
            s2.pdiff <= '0;
         end
         // stage 3: pass product, index rides alongside
         always_ff @(posedge clk) begin
            s3.sum     <= s2.p37 + s2.pdiff;
            s3.idxterm <= idx_w;
         end
      end
   endgenerate

endmodule

// File: rtl/mt_seed_fold.sv
`timescale 1ns/1ps
module mt_seed_fold
   import mt_seed_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  logic    load,
   input  word_t   load_val,
   input  logic    advance,
   input  stage3_t s3,
   output word_t   pend
);

   // stage 4: pending word, written to memory in the next write phase
   always_ff @(posedge clk) begin
      if (rst) begin
         pend <= '0;
      end else if (load) begin
         pend <= load_val;
      end else if (advance) begin
         pend <= s3.sum + s3.idxterm;
      end
   end

endmodule

// File: rtl/mt_seed_expander.sv
`timescale 1ns/1ps
module mt_seed_expander
   import mt_seed_pkg::*;
#(
   parameter int unsigned TABLE_N      = 624,
   parameter logic [31:0] DEFAULT_SEED = 32'd5489,
   parameter bit          SHIFT_ADD    = 1'b1,
   parameter logic [31:0] MULT         = 32'd1812433253,
   localparam int unsigned IDX_W       = $clog2(TABLE_N)
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [31:0]       seed,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_addr,
   output logic [31:0]       wr_data,
   output logic              done
);

   initial begin
      if (TABLE_N < 2)
         $fatal(1, "mt_seed_expander: TABLE_N must be at least 2");
      if (IDX_W >= WORD_W)
         $fatal(1, "mt_seed_expander: index wider than a state word");
      if (SHIFT_ADD && (MULT != MT_INIT_MULT))
         $fatal(1, "mt_seed_expander: shift-add variant fixes MULT");
   end

   logic             load;
   logic             active;
   phase_t           phase;
   logic [IDX_W-1:0] idx;
   word_t            pend;
   word_t            load_val;
   stage3_t          s3;

   assign load_val = start ? seed : DEFAULT_SEED;

   mt_seed_sequencer #(
      .TABLE_N (TABLE_N),
      .IDX_W   (IDX_W)
   ) u_seq (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .load   (load),
      .active (active),
      .phase  (phase),
      .idx    (idx),
      .done   (done)
   );

   mt_seed_mix #(
      .IDX_W     (IDX_W),
      .SHIFT_ADD (SHIFT_ADD),
      .MULT      (MULT)
   ) u_mix (
      .clk     (clk),
      .word_in (pend),
      .idx     (idx),
      .s3      (s3)
   );

   mt_seed_fold u_fold (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .load_val (load_val),
      .advance  (active && phase[PH_LAST]),
      .s3       (s3),
      .pend     (pend)
   );

   assign wr_en   = active && phase[PH_WRITE];
   assign wr_addr = idx;
   assign wr_data = pend;

endmodule

// File: rtl/mt_seed_checker.sv
`timescale 1ns/1ps
module mt_seed_checker #(
   parameter int unsigned TABLE_N      = 624,
   parameter int unsigned IDX_W        = 10,
   parameter logic [31:0] DEFAULT_SEED = 32'd5489
)(
   input logic             clk,
   input logic             rst,
   input logic             start,
   input logic [31:0]      seed,
   input logic             wr_en,
   input logic [IDX_W-1:0] wr_addr,
   input logic [31:0]      wr_data,
   input logic             done,
   input logic             active,
   input logic [3:0]       phase
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TABLE_N - 1);

   // cycles since last write, and whether a fresh sequence just began
   logic             fresh;
   logic [2:0]       gap;
   logic [IDX_W-1:0] last_addr;

   always_ff @(posedge clk) begin
      if (rst || start) begin
         fresh     <= 1'b1;
         gap       <= '0;
         last_addr <= '0;
      end else if (wr_en) begin
         fresh     <= 1'b0;
         gap       <= '0;
         last_addr <= wr_addr;
      end else if (gap != 3'd7) begin
         gap <= gap + 3'd1;
      end
   end

   // R1: after release the default seed goes out first
   p_reset_kick_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) && !start |=> wr_en && wr_addr == '0 && wr_data == DEFAULT_SEED);

   // R2: start pulse yields word 0 carrying the seed
   p_first_word_r2: assert property (@(posedge clk) disable iff (rst)
      start |=> wr_en && wr_addr == '0 && wr_data == $past(seed));

   // R3: four-cycle spacing between writes
   p_write_gap_r3: assert property (@(posedge clk) disable iff (rst)
      wr_en && !fresh |-> gap == 3'd3);

   // R3: addresses step by one
   p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
      wr_en && !fresh |-> wr_addr == last_addr + IDX_W'(1));

   // R3: address stays inside the table
   p_addr_range_r3: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> wr_addr <= LAST_IDX);

   // R3: phase ring is one-hot while running
   p_phase_onehot_r3: assert property (@(posedge clk) disable iff (rst)
      active |-> $countones(phase) == 1);

   // R5: done follows the last write
   p_done_after_last_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> $past(wr_en) && $past(wr_addr) == LAST_IDX);

   // R5: no writes while done
   p_done_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      done |-> !wr_en);

   // R5: done holds until a new start
   p_done_hold_r5: assert property (@(posedge clk) disable iff (rst)
      done && !start |=> done);

   // R7: start clears done
   p_start_clears_r7: assert property (@(posedge clk) disable iff (rst)
      start |=> !done);

endmodule

bind mt_seed_expander mt_seed_checker #(
   .TABLE_N      (TABLE_N),
   .IDX_W        (IDX_W),
   .DEFAULT_SEED (DEFAULT_SEED)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .start   (start),
   .seed    (seed),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .done    (done),
   .active  (active),
   .phase   (phase)
);

// File: tb/mt_seed_expander_bench.sv
`timescale 1ns/1ps
module mt_seed_expander_bench;

   localparam int          N     = 624;
   localparam logic [31:0] DSEED = 32'd5489;

   logic        clk   = 1'b0;
   logic        rst   = 1'b1;
   logic        start = 1'b0;
   logic [31:0] seed  = '0;
   logic        wr_en;
   logic [9:0]  wr_addr;
   logic [31:0] wr_data;
   logic        done;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   mt_seed_expander u_mt_seed_expander (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .seed    (seed),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .done    (done)
   );

   function automatic logic [31:0] model_next(input logic [31:0] w, input int i);
      logic [63:0] p;
      p = 64'd1812433253 * {32'd0, w ^ (w >> 30)};
      return p[31:0] + 32'(i);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_start(input logic [31:0] s);
      @(negedge clk);
      start = 1'b1;
      seed  = s;
      @(negedge clk);
      start = 1'b0;
      seed  = $urandom;
   endtask

   // follows one expansion from the cycle showing word 0 until done
   task automatic collect(input logic [31:0] s, input string req0);
      logic [31:0] w;
      int n, gap, cyc;
      w = s; n = 0; gap = 0; cyc = 0;
      while (!done && cyc < 3000) begin
         if (wr_en) begin
            if (n > 0) check(gap == 4, "R3", "write spacing", gap, 4);
            check(wr_addr == 10'(n), "R3", "write address", wr_addr, n);
            check(wr_data == w, (n == 0) ? req0 : "R4", "state word", wr_data, w);
            if (s == DSEED && n == 1)
               check(wr_data == 32'd1301868182, "R4", "known word 1", wr_data, 32'd1301868182);
            n++;
            w = model_next(w, n);
            gap = 0;
         end
         gap++;
         cyc++;
         @(negedge clk);
      end
      check(n == N, "R5", "words before done", n, N);
      check(cyc == 4*(N-1)+1, "R5", "cycles to done", cyc, 4*(N-1)+1);
   endtask

   task automatic hold_done;
      for (int k = 0; k < 12; k++) begin
         check(done && !wr_en, "R5", "done held, no writes", {done, wr_en}, 2'b10);
         @(negedge clk);
      end
   endtask

   task automatic restart_after(input int k, input logic [31:0] a, input logic [31:0] b);
      do_start(a);
      repeat (k) @(negedge clk);
      check(!done, "R6", "done low mid-run", done, 0);
      do_start(b);
      check(!done, "R6", "done low after restart", done, 0);
      check(wr_en && wr_addr == 10'd0, "R6", "restart at address 0", wr_addr, 0);
      collect(b, "R6");
   endtask

   initial begin
      void'($urandom(32'd7781));
      rst = 1'b1;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check(!wr_en && !done, "R1", "quiet during reset", {wr_en, done}, 0);
      end
      rst = 1'b0;
      @(negedge clk);
      collect(DSEED, "R1");
      hold_done();

      // start after done (R7), directed extremes
      do_start(32'hFFFF_FFFF);
      check(!done, "R7", "done cleared by start", done, 0);
      collect(32'hFFFF_FFFF, "R2");
      do_start(32'h0000_0000);
      collect(32'h0000_0000, "R2");

      // random seeds
      for (int r = 0; r < 2; r++) begin
         logic [31:0] s;
         s = $urandom;
         do_start(s);
         check(!done, "R7", "done cleared by start", done, 0);
         collect(s, "R2");
         hold_done();
      end

      // restarts: random point, right before final write, mid-word
      restart_after(int'($urandom_range(3, 2400)), $urandom, $urandom);
      restart_after(4*(N-1) - 2, 32'h1234_5678, 32'h8765_4321);
      restart_after(2, 32'hDEAD_BEEF, DSEED);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule